// File: doc/BRIEF.md
# Delayed Read Request Queue

This block sits on one direction of a bus bridge. It holds read requests that an initiator has started but that cannot finish until the far-side bus has fetched the data. Every new read is answered with a retry and saved in a slot. A forwarding engine takes the saved requests in arrival order and reports back a completion code and, for a successful read, one DWORD of data. When the initiator repeats the same request, the block returns the stored data. If the far side ended the fetch with a master abort, the block instead declines to claim the repeated cycle, so the initiator sees a master abort too.

Requests are matched on address and command class (prefetchable or not). A repeat of a queued request never takes a second slot. Each completed slot runs a discard timer, limited by `wait_limit`. If the initiator does not come back in time, the slot is dropped and a one-cycle timeout pulse is raised. The configuration that drives `wait_limit` is expected to reset it to `16'h8000` (`DEF_WAIT_LIMIT` in the package).

Slots are allocated round-robin through a tail pointer. A head pointer walks the same ring for forwarding. A new read can be stored only when the slot under the tail pointer is free.

Top module: `drq_queue`

## Requirements
- R1: After reset, `rsp_valid`, `fwd_valid` and `tmo_pulse` are 0.
- R2: A request that matches no held slot, while the tail slot is free, gets a response with code 1 (retry) and is then offered on the forward side with its address.
- R3: A request whose address and prefetch flag equal those of a slot still waiting for completion gets code 1 (retry) and does not take a second slot. After that slot completes, nothing further is offered on the forward side.
- R4: A request that matches no held slot while the tail slot is occupied (which includes all four slots busy) gets code 1 (retry) and is never forwarded.
- R5: Held requests appear on the forward side strictly in arrival order.
- R6: `fwd_be` is 4'b0000 for a prefetchable request (`req_pref`=1). For a non-prefetchable request it equals the initiator's byte enables, and exactly one DWORD is fetched.
- R7: A completion with `cpl_code`=1 (target retry) leaves the same request on the forward side to be issued again. Codes 0 (data) and 2 (master abort) end it and advance to the next request.
- R8: A repeat matching a slot completed with code 0, including equal byte enables, gets code 2 (data) with the stored DWORD on `rsp_data`, and frees the slot. A later identical request is therefore treated as new.
- R9: A repeat matching a slot completed with code 2 (master abort), including equal byte enables, gets code 3 (no claim) and frees the slot.
- R10: A repeat matching a completed slot on address and prefetch flag but with different byte enables gets code 1 (retry). The slot and its data are kept.
- R11: A completed slot that is not collected is discarded `wait_limit`+1 clocks after its completion, with `tmo_pulse` high for one cycle. A slot collected before then is served normally.
- R12: `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` was high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator presents a read request this cycle |
| req_addr | input | AW | Request DWORD address |
| req_pref | input | 1 | 1 = prefetchable read command, 0 = single-DWORD read |
| req_be | input | BEW | Initiator byte enables |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_code | output | 2 | 1 retry, 2 data, 3 no claim |
| rsp_data | output | DW | Returned DWORD when the code is 2 |
| fwd_valid | output | 1 | A held request awaits forwarding |
| fwd_addr | output | AW | Address to issue on the far bus |
| fwd_pref | output | 1 | Command class of the forwarded read |
| fwd_be | output | BEW | Byte enables to drive on the far bus |
| cpl_valid | input | 1 | Forwarding engine reports a result for the offered request |
| cpl_code | input | 2 | 0 data, 1 target retry, 2 master abort |
| cpl_data | input | DW | DWORD fetched, when the code is 0 |
| wait_limit | input | TW | Discard timer limit in clocks |
| tmo_pulse | output | 1 | A completed slot was discarded by its timer |

## Verification
A request captured at a rising edge has its response on the `rsp_*` ports right after that edge, because the code and the data read are both registered once. A new slot, and any change made by a completion, shows up on `fwd_*` directly after the capturing edge. A timer expiry shows up on `tmo_pulse` for the one cycle after the edge at which the slot is freed. The bench drives every input at a falling edge and samples at the following falling edge, so each result is read exactly one capturing edge after its stimulus. The timer is checked with windows well inside and well past the limit.

// File: rtl/drq_pkg.sv
package drq_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_PEND = 2'd1,
    ST_DONE = 2'd2,
    ST_MABT = 2'd3
  } slot_st_e;

  localparam logic [1:0] RSP_RETRY   = 2'd1;
  localparam logic [1:0] RSP_DATA    = 2'd2;
  localparam logic [1:0] RSP_NOCLAIM = 2'd3;

  localparam logic [1:0] CPL_DATA   = 2'd0;
  localparam logic [1:0] CPL_RETRY  = 2'd1;
  localparam logic [1:0] CPL_MABORT = 2'd2;

  localparam logic [15:0] DEF_WAIT_LIMIT = 16'h8000;

endpackage

// File: rtl/drq_entry.sv
module drq_entry
  import drq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BEW = 4,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc,
  input  logic [AW-1:0]  a_addr,
  input  logic           a_pref,
  input  logic [BEW-1:0] a_be,
  input  logic           cpl_ok,
  input  logic           cpl_abt,
  input  logic           release_i,
  input  logic [TW-1:0]  wait_limit,
  output slot_st_e       st,
  output logic [AW-1:0]  e_addr,
  output logic           e_pref,
  output logic [BEW-1:0] e_be,
  output logic           expire
);

  slot_st_e      st_q;
  logic [TW-1:0] timer_q;
  logic          waiting;

  assign st      = st_q;
  assign waiting = (st_q == ST_DONE) || (st_q == ST_MABT);
  assign expire  = waiting && !release_i && (timer_q == wait_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_FREE;
      timer_q <= '0;
    end else begin
      unique case (st_q)
        ST_FREE: begin
          if (alloc) st_q <= ST_PEND;
        end
        ST_PEND: begin
          if (cpl_ok) begin
            st_q    <= ST_DONE;
            timer_q <= '0;
          end else if (cpl_abt) begin
            st_q    <= ST_MABT;
            timer_q <= '0;
          end
        end
        default: begin
          if (release_i || expire) st_q <= ST_FREE;
          else                     timer_q <= timer_q + 1'b1;
        end
      endcase
    end
  end

  // request fields carry no reset: they are only read while the slot is held
  always_ff @(posedge clk) begin
    if (alloc && st_q == ST_FREE) begin
      e_addr <= a_addr;
      e_pref <= a_pref;
      e_be   <= a_be;
    end
  end

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (st_q == ST_FREE)); // R4

  AST_EXPIRE_FREES: assert property (@(posedge clk) disable iff (rst)
    expire |=> (st_q == ST_FREE)); // R11

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && !release_i && !expire) |=> (st_q == ST_DONE)); // R10

  AST_RELEASE_COMPLETED: assert property (@(posedge clk) disable iff (rst)
    release_i |-> waiting); // R8

endmodule

// File: rtl/drq_match.sv
module drq_match
  import drq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int BEW   = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_pref,
  input  logic [BEW-1:0]            req_be,
  input  logic [DEPTH-1:0]          held,
  input  logic [DEPTH-1:0][AW-1:0]  s_addr,
  input  logic [DEPTH-1:0]          s_pref,
  input  logic [DEPTH-1:0][BEW-1:0] s_be,
  output logic [DEPTH-1:0]          hit,
  output logic [DEPTH-1:0]          be_eq,
  output logic                      any_hit,
  output logic [PW-1:0]             hit_idx
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g]   = req_valid && held[g] && (s_addr[g] == req_addr) && (s_pref[g] == req_pref);
    assign be_eq[g] = (s_be[g] == req_be);
  end

  assign any_hit = |hit;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) hit_idx = PW'(i);
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R3

endmodule

// File: rtl/drq_data_ram.sv
module drq_data_ram #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/drq_queue.sv
module drq_queue
  import drq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEW   = 4,
  parameter int TW    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_pref,
  input  logic [BEW-1:0] req_be,
  output logic           rsp_valid,
  output logic [1:0]     rsp_code,
  output logic [DW-1:0]  rsp_data,
  output logic           fwd_valid,
  output logic [AW-1:0]  fwd_addr,
  output logic           fwd_pref,
  output logic [BEW-1:0] fwd_be,
  input  logic           cpl_valid,
  input  logic [1:0]     cpl_code,
  input  logic [DW-1:0]  cpl_data,
  input  logic [TW-1:0]  wait_limit,
  output logic           tmo_pulse
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] head_q, tail_q;

  slot_st_e                  st_v [DEPTH];
  logic [DEPTH-1:0]          held;
  logic [DEPTH-1:0][AW-1:0]  s_addr;
  logic [DEPTH-1:0]          s_pref;
  logic [DEPTH-1:0][BEW-1:0] s_be;
  logic [DEPTH-1:0]          expire_v;
  logic [DEPTH-1:0]          alloc_v, ok_v, abt_v, rel_v;

  logic [DEPTH-1:0] hit, be_eq;
  logic             any_hit;
  logic [PW-1:0]    hit_idx;

  logic     cpl_take, cpl_ok, cpl_abt, cpl_end;
  logic     alloc_go, serve_go;
  slot_st_e hit_st;
  logic [1:0] code_d;

  // forward side: the slot under the head pointer, while it still awaits completion
  assign fwd_valid = (st_v[head_q] == ST_PEND);
  assign fwd_addr  = s_addr[head_q];
  assign fwd_pref  = s_pref[head_q];
  assign fwd_be    = s_pref[head_q] ? '0 : s_be[head_q];

  assign cpl_take = cpl_valid && fwd_valid;
  assign cpl_ok   = cpl_take && (cpl_code == CPL_DATA);
  assign cpl_abt  = cpl_take && (cpl_code == CPL_MABORT);
  assign cpl_end  = cpl_ok || cpl_abt;

  // initiator side decision
  assign hit_st   = st_v[hit_idx];
  assign serve_go = any_hit && be_eq[hit_idx] && ((hit_st == ST_DONE) || (hit_st == ST_MABT));
  assign alloc_go = req_valid && !any_hit && (st_v[tail_q] == ST_FREE);

  always_comb begin
    code_d = RSP_RETRY;
    if (serve_go) code_d = (hit_st == ST_DONE) ? RSP_DATA : RSP_NOCLAIM;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign alloc_v[g] = alloc_go && (tail_q == PW'(g));
    assign ok_v[g]    = cpl_ok   && (head_q == PW'(g));
    assign abt_v[g]   = cpl_abt  && (head_q == PW'(g));
    assign rel_v[g]   = serve_go && (hit_idx == PW'(g));
    assign held[g]    = (st_v[g] != ST_FREE);

    drq_entry #(.AW(AW), .BEW(BEW), .TW(TW)) u_entry (
      .clk        (clk),
      .rst        (rst),
      .alloc      (alloc_v[g]),
      .a_addr     (req_addr),
      .a_pref     (req_pref),
      .a_be       (req_be),
      .cpl_ok     (ok_v[g]),
      .cpl_abt    (abt_v[g]),
      .release_i  (rel_v[g]),
      .wait_limit (wait_limit),
      .st         (st_v[g]),
      .e_addr     (s_addr[g]),
      .e_pref     (s_pref[g]),
      .e_be       (s_be[g]),
      .expire     (expire_v[g])
    );
  end

  drq_match #(.DEPTH(DEPTH), .AW(AW), .BEW(BEW)) u_match (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_pref  (req_pref),
    .req_be    (req_be),
    .held      (held),
    .s_addr    (s_addr),
    .s_pref    (s_pref),
    .s_be      (s_be),
    .hit       (hit),
    .be_eq     (be_eq),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  drq_data_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (cpl_ok),
    .waddr (head_q),
    .wdata (cpl_data),
    .raddr (hit_idx),
    .rdata (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      tail_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      tmo_pulse <= 1'b0;
    end else begin
      if (alloc_go) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
      if (cpl_end)  head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
      rsp_valid <= req_valid;
      rsp_code  <= req_valid ? code_d : 2'd0;
      tmo_pulse <= |expire_v;
    end
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R12

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R12

  AST_RETRY_REISSUES: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && cpl_valid && cpl_code == CPL_RETRY) |=> (fwd_valid && fwd_addr == $past(fwd_addr))); // R7

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> $onehot0(expire_v) || !$past(tmo_pulse)); // R11

endmodule

// File: tb/drq_queue_tb.sv
module drq_queue_tb;
  import drq_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_pref = 1'b0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_data;
  logic        fwd_valid;
  logic [31:0] fwd_addr;
  logic        fwd_pref;
  logic [3:0]  fwd_be;
  logic        cpl_valid = 1'b0;
  logic [1:0]  cpl_code = '0;
  logic [31:0] cpl_data = '0;
  logic [15:0] wait_limit = 16'd1000;
  logic        tmo_pulse;

  int checks = 0;
  int errors = 0;
  int tmo_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drq_queue u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_pref(req_pref), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_pref(fwd_pref), .fwd_be(fwd_be),
    .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_data(cpl_data),
    .wait_limit(wait_limit), .tmo_pulse(tmo_pulse)
  );

  always @(negedge clk) if (!rst && tmo_pulse) tmo_cnt++;

  function automatic logic [3:0] exp_be(input logic pref, input logic [3:0] be);
    return pref ? 4'b0000 : be;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic p, input logic [3:0] be,
                      output logic [1:0] code, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pref = p; req_be = be;
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R12 response one cycle later", {31'd0, rsp_valid}, 32'd1);
    code = rsp_code; data = rsp_data;
    req_valid = 1'b0;
  endtask

  task automatic complete(input logic [1:0] c, input logic [31:0] d);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_code = c; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [1:0]  code;
    logic [31:0] data;
    logic [31:0] a_q [4];
    logic        p_q [4];
    logic [3:0]  b_q [4];
    bit          ab_q [4];
    logic [31:0] d_q [4];
    int          base_tmo;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && fwd_valid === 1'b0 && tmo_pulse === 1'b0, "R1 reset state",
        {29'd0, rsp_valid, fwd_valid, tmo_pulse}, 32'd0);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 no response when idle", {31'd0, rsp_valid}, 32'd0);

    // R2 / R3 / R6 directed: new request, then a repeat while pending
    send(32'h0000_0100, 1'b0, 4'b0110, code, data);
    chk(code == RSP_RETRY, "R2 new request retried", {30'd0, code}, {30'd0, RSP_RETRY});
    chk(fwd_valid && fwd_addr == 32'h0000_0100, "R2 request forwarded", fwd_addr, 32'h0000_0100);
    chk(fwd_be == 4'b0110, "R6 non-prefetch byte enables forwarded", {28'd0, fwd_be}, 32'h6);
    send(32'h0000_0100, 1'b0, 4'b0110, code, data);
    chk(code == RSP_RETRY, "R3 pending repeat retried", {30'd0, code}, {30'd0, RSP_RETRY});
    // R7 target retry keeps the request on the forward side
    complete(CPL_RETRY, 32'h0);
    chk(fwd_valid && fwd_addr == 32'h0000_0100, "R7 reissue after target retry", fwd_addr, 32'h0000_0100);
    complete(CPL_DATA, 32'hCAFE_0001);
    chk(!fwd_valid, "R3 repeat not posted twice", {31'd0, fwd_valid}, 32'd0);
    // R10 different byte enables: retry, slot kept
    send(32'h0000_0100, 1'b0, 4'b1111, code, data);
    chk(code == RSP_RETRY, "R10 byte enable mismatch retried", {30'd0, code}, {30'd0, RSP_RETRY});
    chk(!fwd_valid, "R10 mismatch not queued", {31'd0, fwd_valid}, 32'd0);
    send(32'h0000_0100, 1'b0, 4'b0110, code, data);
    chk(code == RSP_DATA, "R8 data returned", {30'd0, code}, {30'd0, RSP_DATA});
    chk(data == 32'hCAFE_0001, "R8 stored DWORD", data, 32'hCAFE_0001);
    // R8 release: same request is new again
    send(32'h0000_0100, 1'b0, 4'b0110, code, data);
    chk(code == RSP_RETRY && fwd_valid, "R8 slot released, request new", {30'd0, code}, {30'd0, RSP_RETRY});
    complete(CPL_MABORT, 32'h0);
    send(32'h0000_0100, 1'b0, 4'b0110, code, data);
    chk(code == RSP_NOCLAIM, "R9 master abort not claimed", {30'd0, code}, {30'd0, RSP_NOCLAIM});
    chk(!fwd_valid, "R9 slot released", {31'd0, fwd_valid}, 32'd0);

    // R4 / R5: fill every slot, fifth request turned away
    for (int i = 0; i < 4; i++) begin
      send(32'h0000_2000 + 32'(i) * 4, i[0], 4'hF, code, data);
      chk(code == RSP_RETRY, "R2 fill retried", {30'd0, code}, {30'd0, RSP_RETRY});
    end
    send(32'h0000_2FF0, 1'b0, 4'h1, code, data);
    chk(code == RSP_RETRY, "R4 full queue retried", {30'd0, code}, {30'd0, RSP_RETRY});
    for (int i = 0; i < 4; i++) begin
      chk(fwd_valid && fwd_addr == 32'h0000_2000 + 32'(i) * 4, "R5 arrival order", fwd_addr,
          32'h0000_2000 + 32'(i) * 4);
      chk(fwd_be == exp_be(i[0], 4'hF), "R6 byte enables by command class", {28'd0, fwd_be},
          {28'd0, exp_be(i[0], 4'hF)});
      complete(CPL_DATA, 32'hD000_0000 + 32'(i));
    end
    chk(!fwd_valid, "R4 rejected request never forwarded", {31'd0, fwd_valid}, 32'd0);
    for (int i = 3; i >= 0; i--) begin
      send(32'h0000_2000 + 32'(i) * 4, i[0], 4'hF, code, data);
      chk(code == RSP_DATA && data == 32'hD000_0000 + 32'(i), "R8 collect filled slot", data,
          32'hD000_0000 + 32'(i));
    end

    // R11 timer: collected in time, then left to expire
    wait_limit = 16'd10;
    send(32'h0000_3000, 1'b1, 4'h3, code, data);
    complete(CPL_DATA, 32'h1234_5678);
    repeat (5) @(negedge clk);
    send(32'h0000_3000, 1'b1, 4'h3, code, data);
    chk(code == RSP_DATA && data == 32'h1234_5678, "R11 collected before expiry", data, 32'h1234_5678);
    base_tmo = tmo_cnt;
    send(32'h0000_3004, 1'b0, 4'h3, code, data);
    complete(CPL_DATA, 32'h8765_4321);
    repeat (30) @(negedge clk);
    chk(tmo_cnt == base_tmo + 1, "R11 one timeout pulse", 32'(tmo_cnt), 32'(base_tmo + 1));
    send(32'h0000_3004, 1'b0, 4'h3, code, data);
    chk(code == RSP_RETRY && fwd_valid && fwd_addr == 32'h0000_3004, "R11 discarded slot gone",
        {30'd0, code}, {30'd0, RSP_RETRY});
    complete(CPL_MABORT, 32'h0);
    send(32'h0000_3004, 1'b0, 4'h3, code, data);
    chk(code == RSP_NOCLAIM, "R9 cleanup", {30'd0, code}, {30'd0, RSP_NOCLAIM});
    wait_limit = 16'd1000;

    // randomized rounds
    for (int r = 0; r < 12; r++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) begin
        a_q[i]  = 32'h0001_0000 + 32'(r) * 256 + 32'(i) * 4;
        p_q[i]  = 1'($urandom % 2);
        b_q[i]  = 4'($urandom);
        ab_q[i] = ($urandom % 4) == 0;
        d_q[i]  = $urandom;
        send(a_q[i], p_q[i], b_q[i], code, data);
        chk(code == RSP_RETRY, "R2 random new request", {30'd0, code}, {30'd0, RSP_RETRY});
      end
      for (int i = 0; i < n; i++) begin
        int rt;
        chk(fwd_valid && fwd_addr == a_q[i], "R5 random order", fwd_addr, a_q[i]);
        chk(fwd_be == exp_be(p_q[i], b_q[i]), "R6 random byte enables", {28'd0, fwd_be},
            {28'd0, exp_be(p_q[i], b_q[i])});
        rt = int'($urandom % 3);
        for (int k = 0; k < rt; k++) begin
          complete(CPL_RETRY, 32'h0);
          chk(fwd_valid && fwd_addr == a_q[i], "R7 random reissue", fwd_addr, a_q[i]);
        end
        complete(ab_q[i] ? CPL_MABORT : CPL_DATA, d_q[i]);
      end
      chk(!fwd_valid, "R5 random drained", {31'd0, fwd_valid}, 32'd0);
      for (int j = 0; j < n; j++) begin
        int i;
        i = r[0] ? (n - 1 - j) : j;
        send(a_q[i], p_q[i], b_q[i], code, data);
        if (ab_q[i])
          chk(code == RSP_NOCLAIM, "R9 random abort", {30'd0, code}, {30'd0, RSP_NOCLAIM});
        else
          chk(code == RSP_DATA && data == d_q[i], "R8 random data", data, d_q[i]);
      end
    end

    repeat (2) @(negedge clk);
    summary();
  end

endmodule